// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters of the classic 8-bit microcontroller kind. Each channel keeps its count in a low byte and a high byte. It advances on machine cycles (timer) or on falling edges of its own external count pin (counter). A gate input, when selected, qualifies counting with an external interrupt-level pin. One shared configuration byte chooses the source, the gating and one of four operating modes for each channel. Mode 00 gives a 13-bit count, mode 01 a 16-bit count and mode 10 an 8-bit count that reloads. In mode 11, timer 1 is frozen and timer 0 becomes two independent 8-bit counters.

Software reaches the four count bytes and the configuration byte through a small register-select port. Each channel raises a sticky overflow flag that stays set until a clear strobe removes it. The host supplies the run bits, the machine-cycle enable and the raw pins. The pins are synchronised inside the block.

Top module: `dual_tmr`

## Requirements
- R1: After reset, all four count bytes, the configuration byte and both overflow flags read 0.
- R2: reg_sel_i selects the byte to read or write: 0 is timer 0 low, 1 is timer 0 high, 2 is timer 1 low, 3 is timer 1 high and 4 is the configuration byte. Codes 5 to 7 read 0 and a write to them changes nothing. reg_rdata_o shows the selected byte combinationally. A write takes effect at the next clock edge. A write to a count byte replaces that byte's value over the increment of the same cycle, and the increment's overflow is still reported.
- R3: Configuration layout: bit 7 is the timer 1 gate, bit 6 the timer 1 source and bits 5:4 the timer 1 mode. Bit 3 is the timer 0 gate, bit 2 the timer 0 source and bits 1:0 the timer 0 mode. With source = 0, an enabled channel advances once per clock in which cyc_en_i is 1.
- R4: With source = 1, each count pin passes through a two-flop synchroniser. The synchronised level is sampled in machine cycles (cyc_en_i = 1), and the channel advances in a machine cycle whose sample is low after a previous sample that was high. Two such advances can never fall in consecutive clocks.
- R5: A channel is enabled when its run bit is 1 and either its gate bit is 0 or its synchronised gate pin is 1.
- R6: Mode 00 counts 13 bits: the high byte above the low 5 bits of the low byte. Bits 7:5 of the low byte are kept, and wrapping from 0x1FFF to 0 is an overflow.
- R7: Mode 01 counts 16 bits ({high, low}), and wrapping from 0xFFFF to 0 is an overflow.
- R8: Mode 10 advances the low byte alone. An advance from 0xFF loads the low byte from the high byte and is an overflow.
- R9: Mode 11 on timer 1 holds both of its bytes.
- R10: Mode 11 on timer 0 splits it into two halves. The low byte is an 8-bit counter under timer 0's controls, and its wrap from 0xFF sets flag 0. The high byte advances in every machine cycle in which run_i[1] is 1, and its wrap sets flag 1. While timer 0 is split, overflows of timer 1 itself set no flag.
- R11: An overflow sets the channel's flag in ovf_o at the next edge. ovf_clr_i[c] clears flag c at the next edge, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Machine-cycle enable |
| run_i | input | 2 | Run bit per channel (bit c = timer c) |
| gate_pin_i | input | 2 | External interrupt-level pins used by gating |
| cnt_pin_i | input | 2 | External count pins |
| reg_sel_i | input | 3 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| ovf_clr_i | input | 2 | Overflow flag clear strobes |
| ovf_o | output | 2 | Sticky overflow flags |

## Verification
The hardest situations to reach from the ports are those that only show near a wrap. These are the 13-bit carry out of the prescaler, the reload from the high byte and the high half of split timer 0 setting timer 1's flag while timer 1 itself wraps unreported. The stimulus preloads each count byte a few steps below its wrap point before it starts a run. It then runs under random machine-cycle enables, random pins, random clear strobes and run-bit changes. A behavioural model predicts every byte and flag, and the read port is rotated through all select codes so that every register is compared every few clocks.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRESC  = 2'b00,
    MODE_CASC   = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import dual_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PRESC_W   = 5,
  parameter bit          HAS_SPLIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              run_i,
  input  logic              gate_lvl_i,
  input  logic              pin_lvl_i,
  input  chan_cfg_t         cfg_i,
  input  logic              split_run_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              split_ovf_o
);
  localparam int unsigned PW = BYTE_W + PRESC_W;
  localparam int unsigned FW = 2 * BYTE_W;
  localparam logic [PW-1:0]     P_ONE = PW'(1);
  localparam logic [FW-1:0]     F_ONE = FW'(1);
  localparam logic [BYTE_W-1:0] B_ONE = BYTE_W'(1);

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              prev_q, fall, en, tick;
  logic [PW-1:0]     pcnt, pcnt_n;
  logic [FW-1:0]     fcnt_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= 1'b0;
    else if (cyc_en_i) prev_q <= pin_lvl_i;
  end

  assign fall = cyc_en_i & prev_q & ~pin_lvl_i;
  assign en   = run_i & (~cfg_i.gate | gate_lvl_i);
  assign tick = en & (cfg_i.ext ? fall : cyc_en_i);
  assign pcnt = {hi_q, lo_q[PRESC_W-1:0]};
  assign pcnt_n = pcnt + P_ONE;
  assign fcnt_n = {hi_q, lo_q} + F_ONE;

  always_comb begin
    lo_n        = lo_q;
    hi_n        = hi_q;
    ovf_o       = 1'b0;
    split_ovf_o = 1'b0;
    unique case (cfg_i.mode)
      MODE_PRESC: if (tick) begin
        hi_n                = pcnt_n[PW-1:PRESC_W];
        lo_n[PRESC_W-1:0]   = pcnt_n[PRESC_W-1:0];
        ovf_o               = &pcnt;
      end
      MODE_CASC: if (tick) begin
        {hi_n, lo_n} = fcnt_n;
        ovf_o        = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (tick) begin
        lo_n  = (&lo_q) ? hi_q : lo_q + B_ONE;
        ovf_o = &lo_q;
      end
      default: if (HAS_SPLIT) begin
        if (tick) begin
          lo_n  = lo_q + B_ONE;
          ovf_o = &lo_q;
        end
        if (cyc_en_i && split_run_i) begin
          hi_n        = hi_q + B_ONE;
          split_ovf_o = &hi_q;
        end
      end
    endcase
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  assert_edge_rate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall);

  assert_wr_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i));

  assert_casc_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == MODE_CASC && tick && (&{hi_q, lo_q}) && !wr_lo_i && !wr_hi_i)
    |=> ({hi_q, lo_q} == '0));

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == MODE_RELOAD && tick && (&lo_q) && !wr_lo_i && !wr_hi_i)
    |=> lo_q == $past(hi_q));

  assert_presc_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == MODE_PRESC && !tick && !wr_lo_i && !wr_hi_i)
    |=> $stable(lo_q) && $stable(hi_q));

  if (!HAS_SPLIT) begin : g_hold
    assert_t1_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.mode == MODE_SPLIT && !wr_lo_i && !wr_hi_i)
      |=> $stable(lo_q) && $stable(hi_q));
  end
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import dual_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned PRESC_W     = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic [1:0]        run_i,
  input  logic [1:0]        gate_pin_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [1:0]        ovf_clr_i,
  output logic [1:0]        ovf_o
);
  localparam int unsigned NCH = 2;
  localparam logic [SEL_W-1:0] SEL_CFG = SEL_W'(2 * NCH);

  logic [2*NCH-1:0]  pins_s;
  logic [NCH-1:0]    cnt_s, gate_s, wr_lo, wr_hi, ch_ovf, split_ovf, flag_set;
  logic [NCH-1:0]    flag_q;
  logic [BYTE_W-1:0] cfg_q;
  logic [BYTE_W-1:0] lo [NCH];
  logic [BYTE_W-1:0] hi [NCH];
  chan_cfg_t         cfg [NCH];
  logic              t0_split;

  pin_sync #(.WIDTH(2 * NCH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({gate_pin_i, cnt_pin_i}),
    .q_o   (pins_s)
  );
  assign cnt_s  = pins_s[NCH-1:0];
  assign gate_s = pins_s[2*NCH-1:NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cfg_q <= '0;
    else if (reg_we_i && reg_sel_i == SEL_CFG) cfg_q <= reg_wdata_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cfg[c]   = chan_cfg_t'(cfg_q[CFG_W*c +: CFG_W]);
    assign wr_lo[c] = reg_we_i && (reg_sel_i == SEL_W'(2 * c));
    assign wr_hi[c] = reg_we_i && (reg_sel_i == SEL_W'(2 * c + 1));

    tmr_chan #(
      .BYTE_W   (BYTE_W),
      .PRESC_W  (PRESC_W),
      .HAS_SPLIT(c == 0)
    ) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cyc_en_i   (cyc_en_i),
      .run_i      (run_i[c]),
      .gate_lvl_i (gate_s[c]),
      .pin_lvl_i  (cnt_s[c]),
      .cfg_i      (cfg[c]),
      .split_run_i((c == 0) ? run_i[NCH-1] : 1'b0),
      .wr_lo_i    (wr_lo[c]),
      .wr_hi_i    (wr_hi[c]),
      .wdata_i    (reg_wdata_i),
      .lo_o       (lo[c]),
      .hi_o       (hi[c]),
      .ovf_o      (ch_ovf[c]),
      .split_ovf_o(split_ovf[c])
    );
  end

  assign t0_split    = (cfg[0].mode == MODE_SPLIT);
  assign flag_set[0] = ch_ovf[0];
  assign flag_set[1] = t0_split ? split_ovf[0] : (ch_ovf[1] | split_ovf[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~ovf_clr_i) | flag_set;
  end
  assign ovf_o = flag_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_sel_i == SEL_W'(2 * c))     reg_rdata_o = lo[c];
      if (reg_sel_i == SEL_W'(2 * c + 1)) reg_rdata_o = hi[c];
    end
    if (reg_sel_i == SEL_CFG) reg_rdata_o = cfg_q;
  end

  assert_flag_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i[0] && !ch_ovf[0]) |=> !ovf_o[0]);

  assert_flag_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_ovf[0] |=> ovf_o[0]);

  assert_split_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_split && ch_ovf[1] && !split_ovf[0] && !ovf_o[1]) |=> !ovf_o[1]);
endmodule

// File: tb/test_dual_tmr.sv
module test_dual_tmr;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_en_i = 1'b0;
  logic [1:0] run_i = '0, gate_pin_i = '0, cnt_pin_i = '0, ovf_clr_i = '0;
  logic [2:0] reg_sel_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [1:0] ovf_o;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  logic [15:0] lf = 16'hACE1;

  dual_tmr i_dual_tmr (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  int m_lo[2], m_hi[2], m_cfg, m_flag[2];
  logic [1:0] m_cs1, m_cs2, m_gs1, m_gs2, m_prev;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lo = '{0, 0}; m_hi = '{0, 0}; m_cfg = 0; m_flag = '{0, 0};
      m_cs1 = 0; m_cs2 = 0; m_gs1 = 0; m_gs2 = 0; m_prev = 0;
    end else begin
      int nlo[2], nhi[2], ov[2], hov, md, v;
      bit tick[2], ev, en;
      hov = 0;
      for (int c = 0; c < 2; c++) begin
        md = (m_cfg >> (4*c)) & 3;
        ev = cyc_en_i && m_prev[c] && !m_cs2[c];
        en = run_i[c] && (((m_cfg >> (4*c+3)) & 1) == 0 || m_gs2[c]);
        tick[c] = en && ((((m_cfg >> (4*c+2)) & 1) != 0) ? ev : cyc_en_i);
        nlo[c] = m_lo[c]; nhi[c] = m_hi[c]; ov[c] = 0;
        if (md == 0 && tick[c]) begin
          v = m_hi[c] * 32 + (m_lo[c] % 32);
          ov[c] = (v == 8191);
          v = (v + 1) % 8192;
          nhi[c] = v / 32; nlo[c] = (m_lo[c] / 32) * 32 + v % 32;
        end else if (md == 1 && tick[c]) begin
          v = m_hi[c] * 256 + m_lo[c];
          ov[c] = (v == 65535);
          v = (v + 1) % 65536;
          nhi[c] = v / 256; nlo[c] = v % 256;
        end else if (md == 2 && tick[c]) begin
          ov[c] = (m_lo[c] == 255);
          nlo[c] = ov[c] ? m_hi[c] : m_lo[c] + 1;
        end else if (md == 3 && c == 0) begin
          if (tick[c]) begin ov[c] = (m_lo[c] == 255); nlo[c] = (m_lo[c] + 1) % 256; end
          if (cyc_en_i && run_i[1]) begin hov = (m_hi[c] == 255); nhi[c] = (m_hi[c] + 1) % 256; end
        end
      end
      if ((m_cfg & 3) == 3) ov[1] = hov;
      if (reg_we_i) begin
        case (reg_sel_i)
          0: nlo[0] = reg_wdata_i;
          1: nhi[0] = reg_wdata_i;
          2: nlo[1] = reg_wdata_i;
          3: nhi[1] = reg_wdata_i;
          4: m_cfg = reg_wdata_i;
          default: ;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = nlo[c]; m_hi[c] = nhi[c];
        m_flag[c] = (ov[c] != 0) ? 1 : (ovf_clr_i[c] ? 0 : m_flag[c]);
      end
      if (cyc_en_i) m_prev = m_cs2;
      m_cs2 = m_cs1; m_cs1 = cnt_pin_i;
      m_gs2 = m_gs1; m_gs1 = gate_pin_i;
    end
  end

  function automatic int exp_rd(input logic [2:0] s);
    case (s)
      0: return m_lo[0];
      1: return m_hi[0];
      2: return m_lo[1];
      3: return m_hi[1];
      4: return m_cfg;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check($sformatf("rdata sel=%0d", reg_sel_i), int'(reg_rdata_o), exp_rd(reg_sel_i));
      check("ovf", int'(ovf_o), m_flag[1] * 2 + m_flag[0]);
    end
  end

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic wr(input int s, input int d);
    @(negedge clk_i); #1;
    reg_we_i = 1'b1; reg_sel_i = 3'(s); reg_wdata_i = 8'(d);
    @(negedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  // cyc_pat: 0 always, 1 random; pin_pat: 0 hold, 1 random, 2 slow toggle
  task automatic run(input int n, input int cyc_pat, input int pin_pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
      step_lf();
      cyc_en_i  = (cyc_pat == 0) ? 1'b1 : (lf[0] | lf[1]);
      reg_sel_i = 3'(i % 5);
      ovf_clr_i = (lf[15:12] == 4'h0) ? lf[9:8] : 2'b00;
      if (pin_pat == 1) begin
        cnt_pin_i = lf[3:2]; gate_pin_i = lf[5:4];
      end else if (pin_pat == 2) begin
        cnt_pin_i = {i[2], i[1]}; gate_pin_i = {i[5], i[4]};
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: reset values
    for (int s = 0; s < 5; s++) begin
      reg_sel_i = 3'(s); #1;
      check($sformatf("reset sel=%0d", s), int'(reg_rdata_o), 0);
    end
    check("reset ovf", int'(ovf_o), 0);

    tag = "R3"; run_i = 2'b11;
    wr(4, 8'h11); run(300, 1, 0);
    tag = "R7";
    wr(0, 8'hF0); wr(1, 8'hFF); wr(2, 8'hE0); wr(3, 8'hFF);
    run(600, 1, 0);
    tag = "R4";
    wr(4, 8'h55); run(400, 0, 1); run(300, 1, 2);
    wr(0, 8'hFA); wr(1, 8'hFF); run(300, 0, 1);
    tag = "R5";
    wr(4, 8'h99); run(400, 0, 2); run(300, 1, 1);
    run_i = 2'b01; run(200, 0, 1); run_i = 2'b11;
    tag = "R6";
    wr(4, 8'h00); wr(0, 8'hF8); wr(1, 8'hFF); wr(2, 8'h03); wr(3, 8'hFE);
    run(800, 0, 0); run(300, 1, 1);
    tag = "R8";
    wr(4, 8'h22); wr(1, 8'hF0); wr(3, 8'h80); wr(0, 8'hFE); wr(2, 8'hFE);
    run(400, 1, 0); wr(1, 8'h10); run(400, 0, 0);
    tag = "R9";
    wr(4, 8'h31); run(200, 1, 0); wr(2, 8'h5A); run(100, 0, 1);
    tag = "R10";
    wr(2, 8'hF0); wr(3, 8'hFF); wr(0, 8'hF8); wr(1, 8'hF0);
    wr(4, 8'h13); run_i = 2'b10; run(300, 0, 0);
    run_i = 2'b01; run(300, 0, 0);
    run_i = 2'b11; run(300, 1, 1);
    wr(4, 8'h07); run(300, 1, 2);
    tag = "R2";
    wr(4, 8'h11); run(50, 0, 0);
    for (int k = 0; k < 40; k++) begin
      wr(k % 8, k * 37);
      run(7, 1, 1);
    end
    tag = "R11";
    wr(4, 8'h22); wr(1, 8'hFE); wr(3, 8'hFD);
    run(500, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule